// File: doc/BRIEF.md
# Backup Rail Source Selector

This block decides whether the protected memory supply rail is fed from the main supply or from the backup battery. It reads five digitized comparator flags: main supply under the switch threshold, main supply under the battery voltage, main supply under the absolute floor, main supply over the reset threshold, and power-fail input under its threshold. Every flag passes through a two-flop synchronizer before any decision uses it. The reset controller also reports whether reset is currently active.

A four-state machine steers two mutually exclusive switch selects. Its states are on main, gap toward battery, on battery, and gap toward main. A move onto the battery needs one of two things: the supply is under both the switch threshold and the battery voltage, or the supply is under the absolute floor. A move back needs the supply to rise over the reset threshold. That return happens in the same cycle the block stops holding reset, so the rail is back on main one full reset-timeout period before reset releases.

Every source change passes through exactly one cycle with both selects off. While the block is not settled on main, it forces the power-fail output low, turns off the watchdog and manual-reset enables, and requests that reset be held.

Top module: `backup_switch_ctrl`

## Requirements
- R1: After power-on reset (rstN low), mainSelOut=1, battSelOut=0, resetHoldOut=0, and all synchronizer flops read 0.
- R2: Leaving main requires the synchronized belowSwitch AND belowBatt flags together. Either flag alone, for any length of time, keeps the rail on main.
- R3: A synchronized belowFloor flag moves the rail toward the battery no matter what the other flags say.
- R4: On battery, the rail stays there until the synchronized aboveReset flag is 1. Clearing the entry flags alone changes nothing.
- R5: mainSelOut and battSelOut are never both 1. Every change of source shows exactly one cycle with both at 0.
- R6: On main, pfoNOut is 0 when the synchronized pfiLow or belowSwitch flag is 1, and 1 otherwise.
- R7: Whenever the state is not main (either gap or battery), pfoNOut=0, wdEnableOut=0, mrEnableOut=0 and resetHoldOut=1.
- R8: On main, mrEnableOut=1, and wdEnableOut is the inverse of resetActiveIn in the same cycle.
- R9: A flag change driven before clock edge k takes effect in state at edge k+2, so the selects change after edge k+2. mainSelOut rises in the same cycle that resetHoldOut falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| belowSwitchIn | input | 1 | Main supply under switch threshold (async) |
| belowBattIn | input | 1 | Main supply under battery voltage (async) |
| belowFloorIn | input | 1 | Main supply under absolute floor (async) |
| aboveResetIn | input | 1 | Main supply over reset threshold (async) |
| pfiLowIn | input | 1 | Power-fail input under its threshold (async) |
| resetActiveIn | input | 1 | Reset controller currently asserting reset |
| mainSelOut | output | 1 | Close main-supply switch |
| battSelOut | output | 1 | Close battery switch |
| pfoNOut | output | 1 | Active-low power-fail output |
| wdEnableOut | output | 1 | Watchdog logic enable |
| mrEnableOut | output | 1 | Manual-reset logic enable |
| resetHoldOut | output | 1 | Request reset controller to hold reset |

## Verification
The bench goes after the two half-conditions for entry. If the design read the AND as an OR, a battery that merely sits above the supply would pull the rail away. It holds the supply under the floor with the battery flag clear; a design that tied entry only to the battery comparison would stay on main. It clears every entry flag while on battery but keeps aboveReset low; a design that leaves backup early would return to main there. It also counts the selects' zero gap on every transition, which catches a make-before-break design or a gap of two cycles, and it compares pfoNOut and the enables cycle by cycle, which catches power-fail gating that lags the state.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  localparam int FLAG_W        = 5;
  localparam int FL_BELOW_SW   = 0;
  localparam int FL_BELOW_BATT = 1;
  localparam int FL_BELOW_FLR  = 2;
  localparam int FL_ABOVE_RST  = 3;
  localparam int FL_PFI_LOW    = 4;

  typedef enum logic [1:0] {
    ST_MAIN    = 2'd0,
    ST_TO_BATT = 2'd1,
    ST_BACKUP  = 2'd2,
    ST_TO_MAIN = 2'd3
  } srcState_t;

  typedef struct packed {
    logic driveMain;
    logic driveBatt;
    logic settledMain;
  } railStrobe_t;
endpackage

// File: rtl/bkup_flag_sync.sv
module bkup_flag_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= '0;
        else       chain[0] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/bkup_ctrl.sv
module bkup_ctrl
  import bkup_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] flags,
  output railStrobe_t       strobe
);
  srcState_t state, stateNext;
  logic enterBatt, leaveBatt;

  assign enterBatt = (flags[FL_BELOW_SW] && flags[FL_BELOW_BATT]) || flags[FL_BELOW_FLR];
  assign leaveBatt = flags[FL_ABOVE_RST];

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_MAIN:    if (enterBatt) stateNext = ST_TO_BATT;
      ST_TO_BATT: stateNext = ST_BACKUP;
      ST_BACKUP:  if (leaveBatt) stateNext = ST_TO_MAIN;
      ST_TO_MAIN: stateNext = ST_MAIN;
      default:    stateNext = ST_MAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_MAIN;
    else       state <= stateNext;
  end

  assign strobe.driveMain   = (state == ST_MAIN);
  assign strobe.driveBatt   = (state == ST_BACKUP);
  assign strobe.settledMain = (state == ST_MAIN);

  // R2: no departure from main without a qualifying entry condition
  a_r2_stay_main: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MAIN && !flags[FL_BELOW_FLR] &&
     !(flags[FL_BELOW_SW] && flags[FL_BELOW_BATT])) |=> state == ST_MAIN);

  // R3: floor always forces departure from main
  a_r3_floor_leaves: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MAIN && flags[FL_BELOW_FLR]) |=> state == ST_TO_BATT);

  // R4: battery held until supply exceeds reset threshold
  a_r4_hold_batt: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BACKUP && !flags[FL_ABOVE_RST]) |=> state == ST_BACKUP);

  // R5: each gap lasts a single cycle
  a_r5_gap_one: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TO_BATT || state == ST_TO_MAIN) |=> (state == ST_BACKUP || state == ST_MAIN));
endmodule

// File: rtl/bkup_datapath.sv
module bkup_datapath
  import bkup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  railStrobe_t strobe,
  input  logic        pfiLowS,
  input  logic        belowSwS,
  input  logic        resetActive,
  output logic        mainSel,
  output logic        battSel,
  output logic        pfoN,
  output logic        wdEnable,
  output logic        mrEnable,
  output logic        resetHold
);
  assign mainSel   = strobe.driveMain;
  assign battSel   = strobe.driveBatt;
  assign pfoN      = strobe.settledMain && !(pfiLowS || belowSwS);
  assign wdEnable  = strobe.settledMain && !resetActive;
  assign mrEnable  = strobe.settledMain;
  assign resetHold = !strobe.settledMain;

  // R5: break-before-make, both switches never closed together
  a_r5_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(mainSel && battSel));

  // R5: battery switch closes only after a cycle with main open
  a_r5_gap_before_batt: assert property (@(posedge clk) disable iff (!rstN)
    $rose(battSel) |-> $past(!mainSel));
endmodule

// File: rtl/backup_switch_ctrl.sv
module backup_switch_ctrl
  import bkup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic belowSwitchIn,
  input  logic belowBattIn,
  input  logic belowFloorIn,
  input  logic aboveResetIn,
  input  logic pfiLowIn,
  input  logic resetActiveIn,
  output logic mainSelOut,
  output logic battSelOut,
  output logic pfoNOut,
  output logic wdEnableOut,
  output logic mrEnableOut,
  output logic resetHoldOut
);
  logic [FLAG_W-1:0] rawFlags, syncFlags;
  railStrobe_t strobe;

  always_comb begin
    rawFlags                = '0;
    rawFlags[FL_BELOW_SW]   = belowSwitchIn;
    rawFlags[FL_BELOW_BATT] = belowBattIn;
    rawFlags[FL_BELOW_FLR]  = belowFloorIn;
    rawFlags[FL_ABOVE_RST]  = aboveResetIn;
    rawFlags[FL_PFI_LOW]    = pfiLowIn;
  end

  bkup_flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(rawFlags), .syncOut(syncFlags));

  bkup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flags(syncFlags), .strobe(strobe));

  bkup_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pfiLowS(syncFlags[FL_PFI_LOW]), .belowSwS(syncFlags[FL_BELOW_SW]),
    .resetActive(resetActiveIn),
    .mainSel(mainSelOut), .battSel(battSelOut), .pfoN(pfoNOut),
    .wdEnable(wdEnableOut), .mrEnable(mrEnableOut), .resetHold(resetHoldOut));

  // R7: whenever the battery feeds the rail, everything else is gated
  a_r7_batt_gates: assert property (@(posedge clk) disable iff (!rstN)
    battSelOut |-> (!pfoNOut && !wdEnableOut && !mrEnableOut && resetHoldOut));

  // R9: main reconnects in the same cycle the reset hold drops
  a_r9_main_with_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainSelOut) |-> $fell(resetHoldOut));
endmodule

// File: tb/backup_switch_ctrl_bench.sv
module backup_switch_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN;
  logic belowSw, belowBatt, belowFloor, aboveRst, pfiLow, rstActive;
  logic mainSel, battSel, pfoN, wdEn, mrEn, rstHold;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model: bit order {pfi, above, floor, batt, sw}
  logic [4:0] m1, m2;
  int ms; // 0 main, 1 gap to batt, 2 battery, 3 gap to main

  always #(CLK_PERIOD/2) clk = ~clk;

  backup_switch_ctrl u_backup_switch_ctrl (
    .clk(clk), .rstN(rstN),
    .belowSwitchIn(belowSw), .belowBattIn(belowBatt), .belowFloorIn(belowFloor),
    .aboveResetIn(aboveRst), .pfiLowIn(pfiLow), .resetActiveIn(rstActive),
    .mainSelOut(mainSel), .battSelOut(battSel), .pfoNOut(pfoN),
    .wdEnableOut(wdEn), .mrEnableOut(mrEn), .resetHoldOut(rstHold));

  task automatic check(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cycles, got, exp);
    end
  endtask

  function automatic int nextState(input int s, input logic [4:0] f);
    case (s)
      0: return ((f[0] && f[1]) || f[2]) ? 1 : 0;
      1: return 2;
      2: return f[3] ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic compareAll();
    check("R5 mainSel", mainSel, ms == 0);
    check("R5 battSel", battSel, ms == 2);
    check("R6 R7 pfoN", pfoN, (ms == 0) && !(m2[4] || m2[0]));
    check("R8 wdEnable", wdEn, (ms == 0) && !rstActive);
    check("R7 R8 mrEnable", mrEn, ms == 0);
    check("R7 R9 resetHold", rstHold, ms != 0);
  endtask

  // drive at negedge, step one clock, compare at next negedge
  task automatic step(input logic [4:0] f, input logic ra);
    {pfiLow, aboveRst, belowFloor, belowBatt, belowSw} = f;
    rstActive = ra;
    @(posedge clk);
    ms = nextState(ms, m2);
    m2 = m1;
    m1 = f;
    @(negedge clk);
    compareAll();
  endtask

  task automatic hold(input logic [4:0] f, input int n);
    for (int i = 0; i < n; i++) step(f, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] cur;
    void'($urandom(32'd1234));
    rstN = 1'b0;
    {pfiLow, aboveRst, belowFloor, belowBatt, belowSw} = '0;
    rstActive = 1'b0;
    m1 = '0; m2 = '0; ms = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mainSel", mainSel, 1'b1);
    check("R1 battSel", battSel, 1'b0);
    check("R1 resetHold", rstHold, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: battery above supply alone keeps main
    hold(5'b00010, 8);
    check("R2 batt-only stays main", mainSel, 1'b1);
    // R2 R6: below switch alone keeps main, pfo low
    hold(5'b00001, 8);
    check("R2 sw-only stays main", mainSel, 1'b1);
    check("R6 pfo low on sw", pfoN, 1'b0);
    // R2 R9: both -> gap after two synced edges, battery after three
    step(5'b00011, 1'b0);
    step(5'b00011, 1'b0);
    check("R9 no change yet", mainSel, 1'b1);
    step(5'b00011, 1'b0);
    check("R5 gap main off", mainSel, 1'b0);
    check("R5 gap batt off", battSel, 1'b0);
    step(5'b00011, 1'b0);
    check("R2 on battery", battSel, 1'b1);
    // R4: entry flags cleared, still on battery
    hold(5'b00000, 10);
    check("R4 stays on battery", battSel, 1'b1);
    check("R7 pfo forced low", pfoN, 1'b0);
    // R4 R9: above reset returns
    hold(5'b01000, 5);
    check("R4 back to main", mainSel, 1'b1);
    check("R9 hold released", rstHold, 1'b0);
    // R3: floor only
    hold(5'b00100, 5);
    check("R3 floor to battery", battSel, 1'b1);
    hold(5'b01000, 5);
    // R6: pfi low on main
    hold(5'b10000, 4);
    check("R6 pfo low on pfi", pfoN, 1'b0);
    hold(5'b00000, 4);
    check("R6 pfo high idle", pfoN, 1'b1);
    // R8: reset active masks watchdog enable
    step(5'b00000, 1'b1);
    check("R8 wd masked", wdEn, 1'b0);
    check("R8 mr enabled", mrEn, 1'b1);

    // random phase with persistent flags
    cur = '0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) cur = 5'($urandom());
      step(cur, 1'($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule